// File: doc/BRIEF.md
# Banked Digital I/O Port Registers

This block holds a bank of 8-bit digital I/O ports behind a byte-wide register bus. Each port owns two bytes in the address map, sixteen bytes apart from its neighbour: a data byte and a direction byte. A write to the data byte loads the port's output latch, which drives the pins. A read of the data byte returns the pin levels after a two-flop synchroniser. The direction byte decides whether a bidirectional port drives its pins, and that choice covers all eight lines of the port at once.

Each port is built as one of three kinds, set by a build parameter: input-only, output-only or bidirectional. A second build option inverts the output polarity. When it is set, the latch is complemented on its way to the pins, and output-only ports complement their readback again so that software reads back the value it wrote. Bidirectional and input-only ports never invert their readback.

The bus side has a small response machine with two states. `BUS_IDLE` holds `rdata` at zero. `BUS_RESP` presents the byte captured on the previous edge. The transition `IDLE->RESP` (or `RESP->RESP`) is taken on every cycle with `re` high, and `RESP->IDLE` (or `IDLE->IDLE`) on every cycle with `re` low.

Top module: `dio_port_bank`

## Requirements
- R1: The byte at address 0x00 always reads `ID_VALUE`, and writes to it change nothing.
- R2: Port n (n < `NUM_PORTS`) has its data byte at 0x40+16n and its direction byte at 0x41+16n. Every other address, including the data and direction bytes of ports n >= `NUM_PORTS`, reads 0x00, and a write to it leaves all latches and directions unchanged.
- R3: `rdata` carries the addressed byte in the cycle after a cycle with `re` high, and is 0x00 in every other cycle.
- R4: When a read and a write to the same register share a cycle, the read returns the contents from before the write.
- R5: On a bidirectional port, bit 0 of the direction byte selects input (1) or output (0). The direction resets to input. All eight `pin_oe` bits of the port are the inverse of this bit, and the byte reads back as {7'b0, bit}.
- R6: On an input-only port, `pin_oe` is always 0x00, the direction byte reads 0x01, and writes to it are ignored.
- R7: On an output-only port, `pin_oe` is always 0xFF, the direction byte reads 0x00, and writes to it are ignored.
- R8: A data write stores the byte in the port latch. `pin_o` equals the latch when `INVERT_OUT`=0 and its complement when `INVERT_OUT`=1, whatever the direction. Latches reset to 0x00, so the pins start at 0x00, or at 0xFF under inversion.
- R9: A data read returns `pin_i` of that port through two flops. The value is complemented only on output-only ports built with `INVERT_OUT`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write byte |
| we | input | 1 | Write strobe, single cycle |
| re | input | 1 | Read strobe, single cycle |
| rdata | output | 8 | Read byte, valid the cycle after `re` |
| pin_i | input | 8*NUM_PORTS | Pin levels seen at the pads |
| pin_o | output | 8*NUM_PORTS | Values driven toward the pads |
| pin_oe | output | 8*NUM_PORTS | Per-line drive enable, 1 = drive |

## Verification
A read and a write can land on the same direction register in the same bus cycle. The bench provokes this by raising `we` and `re` together at a bidirectional port's direction byte while it still holds its reset value of input. The scoreboard expects the old byte 0x01 in the response cycle, then 0x00 on a separate read that follows, and it sees the port's `pin_oe` go to all ones. Two instances, one with inversion and one without, share every bus cycle. This separates latch inversion from readback inversion on each kind of port.

// File: rtl/dio_bank_pkg.sv
package dio_bank_pkg;
    localparam logic [1:0] KIND_IN    = 2'd0;
    localparam logic [1:0] KIND_OUT   = 2'd1;
    localparam logic [1:0] KIND_BIDIR = 2'd2;

    localparam int PORT_BITS   = 8;
    localparam int MAX_PORTS   = 12;
    localparam int BANK_NIBBLE = 4;   // ports start at 0x40
    localparam logic [3:0] OFS_DATA = 4'h0;
    localparam logic [3:0] OFS_DIR  = 4'h1;

    typedef enum logic [1:0] {
        RS_NONE,
        RS_ID,
        RS_DATA,
        RS_DIR
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;
endpackage

// File: rtl/dio_addr_decode.sv
module dio_addr_decode
    import dio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output reg_sel_e             sel,
    output logic [NUM_PORTS-1:0] port_hit
);
    localparam int UPW = ADDR_W - 4;

    logic [UPW-1:0] upper;
    logic [3:0]     low;
    logic           slot_ok;

    assign upper   = addr[ADDR_W-1:4];
    assign low     = addr[3:0];
    assign slot_ok = (low == OFS_DATA) || (low == OFS_DIR);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        assign port_hit[p] = slot_ok && (upper == UPW'(BANK_NIBBLE + p));
    end

    always_comb begin
        if (addr == '0)
            sel = RS_ID;
        else if (|port_hit)
            sel = (low == OFS_DATA) ? RS_DATA : RS_DIR;
        else
            sel = RS_NONE;
    end
endmodule

// File: rtl/dio_port_slice.sv
module dio_port_slice
    import dio_bank_pkg::*;
#(
    parameter int         PORT_W     = 8,
    parameter logic [1:0] KIND       = KIND_BIDIR,
    parameter bit         INVERT_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_data,
    input  logic              we_dir,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_i,
    output logic [PORT_W-1:0] pin_o,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] data_rd,
    output logic              dir_in,
    output logic [PORT_W-1:0] latch_q
);
    logic [PORT_W-1:0] sync1_q, sync2_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (we_data)
            latch_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
        end
    end

    assign pin_o  = INVERT_OUT ? ~latch_q : latch_q;
    assign pin_oe = {PORT_W{~dir_in}};

    if (KIND == KIND_BIDIR) begin : g_dir_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                dir_in <= 1'b1;
            else if (we_dir)
                dir_in <= wdata[0];
        end
    end else begin : g_dir_fixed
        logic unused_dir_we;
        assign unused_dir_we = we_dir;
        assign dir_in = (KIND == KIND_IN);
    end

    if (KIND == KIND_OUT && INVERT_OUT) begin : g_rd_inv
        assign data_rd = ~sync2_q;
    end else begin : g_rd_plain
        assign data_rd = sync2_q;
    end

    // R8
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_data |=> latch_q == $past(wdata));

    if (KIND == KIND_BIDIR) begin : g_dir_chk
        // R5
        dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we_dir |=> (dir_in == $past(wdata[0])) && (pin_oe == {PORT_W{~$past(wdata[0])}}));
    end
endmodule

// File: rtl/dio_port_bank.sv
module dio_port_bank
    import dio_bank_pkg::*;
#(
    parameter int                   NUM_PORTS  = 4,
    parameter int                   ADDR_W     = 8,
    parameter logic [2*NUM_PORTS-1:0] PORT_KIND = 8'hA4,
    parameter bit                   INVERT_OUT = 1'b0,
    parameter logic [7:0]           ID_VALUE   = 8'hA5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [7:0]                     wdata,
    input  logic                           we,
    input  logic                           re,
    output logic [7:0]                     rdata,
    input  logic [PORT_BITS*NUM_PORTS-1:0] pin_i,
    output logic [PORT_BITS*NUM_PORTS-1:0] pin_o,
    output logic [PORT_BITS*NUM_PORTS-1:0] pin_oe
);
    localparam int PW     = PORT_BITS;
    localparam int TOTALW = PW * NUM_PORTS;

    reg_sel_e             sel;
    logic [NUM_PORTS-1:0] port_hit;
    logic [PW-1:0]        data_rd_a [NUM_PORTS];
    logic [NUM_PORTS-1:0] dir_in_a;
    logic [TOTALW-1:0]    latch_all;
    logic [7:0]           rd_mux;
    logic [7:0]           cap_q;
    bus_state_e           state_q, state_nxt;

    dio_addr_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
        .addr     (addr),
        .sel      (sel),
        .port_hit (port_hit)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dio_port_slice #(
            .PORT_W     (PW),
            .KIND       (PORT_KIND[2*p +: 2]),
            .INVERT_OUT (INVERT_OUT)
        ) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_data (we && port_hit[p] && (sel == RS_DATA)),
            .we_dir  (we && port_hit[p] && (sel == RS_DIR)),
            .wdata   (wdata),
            .pin_i   (pin_i[PW*p +: PW]),
            .pin_o   (pin_o[PW*p +: PW]),
            .pin_oe  (pin_oe[PW*p +: PW]),
            .data_rd (data_rd_a[p]),
            .dir_in  (dir_in_a[p]),
            .latch_q (latch_all[PW*p +: PW])
        );
    end

    always_comb begin
        logic [PW-1:0] data_any;
        logic          dir_any;
        data_any = '0;
        dir_any  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_hit[p]) begin
                data_any = data_any | data_rd_a[p];
                dir_any  = dir_any | dir_in_a[p];
            end
        end
        unique case (sel)
            RS_ID:   rd_mux = ID_VALUE;
            RS_DATA: rd_mux = data_any;
            RS_DIR:  rd_mux = {7'b0, dir_any};
            default: rd_mux = 8'h00;
        endcase
    end

    always_comb state_nxt = re ? BUS_RESP : BUS_IDLE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            cap_q   <= 8'h00;
        end else begin
            state_q <= state_nxt;
            if (re)
                cap_q <= rd_mux;
        end
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE: rdata = 8'h00;
            BUS_RESP: rdata = cap_q;
            default:  rdata = 8'h00;
        endcase
    end

    // R3
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata != 8'h00) |-> $past(re));

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_hit));

    // R2
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel != RS_DATA && sel != RS_DIR) |=> $stable(latch_all) && $stable(dir_in_a));
endmodule

// File: tb/dio_port_bank_test.sv
module dio_port_bank_test;
    localparam int NP = 4;
    localparam int W  = 8 * NP;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic         we = 1'b0;
    logic         re = 1'b0;
    logic [7:0]   rdata, rdata_i;
    logic [W-1:0] ext;
    logic [W-1:0] pin_i, pin_o, pin_oe, pin_i_i, pin_o_i, pin_oe_i;

    int checks = 0;
    int bad = 0;
    logic [7:0] exp0_q[$];
    logic [7:0] exp1_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    assign pin_i   = (pin_oe & pin_o) | (~pin_oe & ext);
    assign pin_i_i = (pin_oe_i & pin_o_i) | (~pin_oe_i & ext);

    dio_port_bank #(.INVERT_OUT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
        .rdata(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe));

    dio_port_bank #(.INVERT_OUT(1'b1)) uut_inv (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
        .rdata(rdata_i), .pin_i(pin_i_i), .pin_o(pin_o_i), .pin_oe(pin_oe_i));

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] e0, logic [7:0] e1, string tag);
        @(negedge clk);
        addr = a; re = 1'b1;
        exp0_q.push_back(e0); exp1_q.push_back(e1); tag_q.push_back(tag);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic rd_wr(logic [7:0] a, logic [7:0] d, logic [7:0] e0, logic [7:0] e1, string tag);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1; re = 1'b1;
        exp0_q.push_back(e0); exp1_q.push_back(e1); tag_q.push_back(tag);
        @(negedge clk);
        we = 1'b0; re = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pop expected bytes as responses appear
    initial begin
        forever begin
            @(posedge clk);
            if (re) begin
                @(negedge clk);
                if (tag_q.size() == 0) begin
                    checks++; bad++;
                    $display("FAIL R3 unexpected response actual=%h expected=none", rdata);
                end else begin
                    logic [7:0] e0, e1;
                    string t;
                    e0 = exp0_q.pop_front(); e1 = exp1_q.pop_front(); t = tag_q.pop_front();
                    check({t, " plain"}, W'(rdata), W'(e0));
                    check({t, " inverted"}, W'(rdata_i), W'(e1));
                end
            end
        end
    end

    initial begin
        fork
            begin
                ext = {8'h81, 8'hC3, 8'h00, 8'h3C};
                idle(3);
                rst_n = 1'b1;
                idle(3);
                check("R8 reset pin_o plain", pin_o, '0);
                check("R8 reset pin_o inverted", pin_o_i, '1);
                check("R5 R6 R7 reset pin_oe", pin_oe, 32'h0000_FF00);
                check("R3 idle rdata", W'(rdata), '0);
                rd(8'h00, 8'hA5, 8'hA5, "R1 id");
                rd(8'h61, 8'h01, 8'h01, "R5 reset dir p2");
                rd(8'h71, 8'h01, 8'h01, "R5 reset dir p3");
                rd(8'h40, 8'h3C, 8'h3C, "R9 input port");
                rd(8'h41, 8'h01, 8'h01, "R6 dir of input port");
                rd(8'h51, 8'h00, 8'h00, "R7 dir of output port");
                idle(1);
                check("R3 idle after reads", W'(rdata), '0);

                wr(8'h50, 8'h96);
                idle(3);
                check("R8 out port pin_o plain", W'(pin_o[15:8]), W'(8'h96));
                check("R8 out port pin_o inverted", W'(pin_o_i[15:8]), W'(8'h69));
                rd(8'h50, 8'h96, 8'h96, "R9 out port readback");

                wr(8'h60, 8'h5A);
                idle(3);
                check("R8 bidir latch drives pin_o in input mode", W'(pin_o_i[23:16]), W'(8'hA5));
                rd(8'h60, 8'hC3, 8'hC3, "R9 bidir as input");
                wr(8'h61, 8'h00);
                idle(3);
                check("R5 bidir output oe", W'(pin_oe[23:16]), W'(8'hFF));
                rd(8'h60, 8'h5A, 8'hA5, "R9 bidir as output");
                rd(8'h61, 8'h00, 8'h00, "R5 dir readback");

                wr(8'h51, 8'h01);
                rd(8'h51, 8'h00, 8'h00, "R7 dir write ignored");
                check("R7 oe stays", W'(pin_oe_i[15:8]), W'(8'hFF));
                wr(8'h41, 8'h00);
                rd(8'h41, 8'h01, 8'h01, "R6 dir write ignored");
                check("R6 oe stays", W'(pin_oe[7:0]), W'(8'h00));

                rd(8'h42, 8'h00, 8'h00, "R2 unmapped offset");
                rd(8'h80, 8'h00, 8'h00, "R2 absent port");
                wr(8'h80, 8'hFF);
                wr(8'h52, 8'h00);
                idle(2);
                check("R2 unmapped write plain", pin_o, {8'h00, 8'h5A, 8'h96, 8'h00});
                check("R2 unmapped write inverted", pin_o_i, {8'hFF, 8'hA5, 8'h69, 8'hFF});
                wr(8'h00, 8'h11);
                rd(8'h00, 8'hA5, 8'hA5, "R1 id write ignored");

                rd_wr(8'h71, 8'h00, 8'h01, 8'h01, "R4 same-cycle old value");
                rd(8'h71, 8'h00, 8'h00, "R4 new value after");
                check("R4 oe after same-cycle write", W'(pin_oe[31:24]), W'(8'hFF));
                wr(8'h71, 8'h01);
                idle(3);
                rd(8'h70, 8'h81, 8'h81, "R9 bidir back to input");
                idle(3);
                check("R3 queue drained", W'(tag_q.size()), '0);
            end
            begin
                idle(20000);
                checks++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule